// File: doc/BRIEF.md
# Stall Buffer with Age-Ordered Wake-Up and Dispatch

This block parks instructions that cannot make progress at a pipeline stage and releases them once the operand cache reports that the lines they wait on have changed state. Each occupied slot records the instruction's thread, a data word, a destination cache-line number, two source cache-line numbers and three pending conditions: source A not yet written, source B not yet written, and destination still held by an earlier reader. A line-write event compares its line number against every source slot in the buffer at the same time. Every matching waiter is therefore woken in one cycle, however many there are.

A square bit matrix with one row and one column per slot records which occupied slots were inserted before which others. Dispatch uses this matrix to offer the oldest ready slot. The choice ignores thread, so an instruction from a different thread can go ahead of one that is still stalled. An external delete request can remove a slot without dispatching it. This is used when a plain load into a register-like location is folded into the instruction that follows it.

Both data streams use valid/ready. The insert port raises `in_ready` whenever a slot is free. An instruction is taken on any rising edge with `in_valid` and `in_ready` both high. The dispatch port holds its offer while `out_ready` is low, and a slot is retired on an edge with `out_valid` and `out_ready` both high. The event and delete pins are plain single-cycle strobes.

Top module: `sb_stall_buffer`

## Requirements
- R1: After reset the buffer is empty, `out_valid` is 0 and `in_ready` is 1.
- R2: An instruction is stored on a rising edge where `in_valid` and `in_ready` are both high. If none of its pending conditions is set, it is offered on the dispatch port in the next cycle, with the thread, data and destination line it was inserted with.
- R3: The buffer holds `N_ENTRIES` instructions. `in_ready` is 0 exactly when every slot is occupied, and an `in_valid` presented while `in_ready` is 0 stores nothing.
- R4: A write event (`wr_evt_valid` with `wr_evt_line`) clears the source-A wait of every occupied slot whose source-A line matches, and the source-B wait of every slot whose source-B line matches, all on the same edge. Slots waiting on other lines are not affected.
- R5: Of the ready slots, the dispatch port offers the one inserted earliest. This holds even when slots are freed and reused, and at most one slot leaves per cycle.
- R6: A delete request (`del_valid` with slot number `del_idx`) frees that slot, and the slot is never dispatched. During the delete cycle the deleted slot is not offered, so the next-oldest ready slot is offered in its place.
- R7: If an insert and an event naming the same line occur in the same cycle, the new slot's matching wait is already cleared when it is stored. A write event clears source waits and a read event clears destination-busy.
- R8: A slot with destination-busy set becomes ready only after a read event (`rd_evt_valid` with `rd_evt_line`) on its destination line. A write event on that line, or a read event on another line, leaves it waiting.
- R9: While `out_valid` is 1 and `out_ready` is 0, the offered slot stays in the buffer and `out_valid` stays 1, unless a delete is requested. If no older slot becomes ready, the offered payload does not change.
- R10: Dispatch does not depend on thread. Slots from several threads that wait on one line leave in insertion order, each carrying its own thread number on `out_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Insert request |
| in_ready | output | 1 | A slot is free |
| in_tid | input | TID_W | Thread number of the inserted instruction |
| in_data | input | DATA_W | Data slot contents |
| in_dst | input | LINE_W | Destination cache line |
| in_src_a | input | LINE_W | Source A cache line |
| in_wait_a | input | 1 | Source A not yet written |
| in_src_b | input | LINE_W | Source B cache line |
| in_wait_b | input | 1 | Source B not yet written |
| in_dst_busy | input | 1 | Destination still awaiting an earlier read |
| wr_evt_valid | input | 1 | A cache line was written |
| wr_evt_line | input | LINE_W | Line that was written |
| rd_evt_valid | input | 1 | A cache line was read |
| rd_evt_line | input | LINE_W | Line that was read |
| del_valid | input | 1 | Delete request |
| del_idx | input | IDX_W | Slot to delete |
| out_valid | output | 1 | A ready slot is offered |
| out_ready | input | 1 | Downstream accepts the offer |
| out_idx | output | IDX_W | Slot number of the offer |
| out_tid | output | TID_W | Thread of the offer |
| out_data | output | DATA_W | Data of the offer |
| out_dst | output | LINE_W | Destination line of the offer |

## Verification
One corner case is a slot that is freed and then reused while an older slot is still waiting. A design that ranked slots by index instead of by the matrix would then dispatch the reused, younger slot first. Another is a single write event that must wake waiters in both source positions and across several threads. A design whose comparison skipped a slot, or only matched source A, would leave an instruction stuck forever. Further cases are an event arriving in the same cycle as the insert it concerns, where a design that missed the bypass would deadlock, and a delete of the slot currently offered, where a design without masking would hand out a deleted instruction. The remaining cases are insertion when the buffer is full, which must not overwrite a slot, and a write event on a destination-busy line, which must not release that slot.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Pending conditions of one buffered instruction.
  typedef struct packed {
    logic busy_dst;  // destination still has an earlier reader
    logic wait_b;    // source B line not yet written
    logic wait_a;    // source A line not yet written
  } sb_flags_t;

endpackage

// File: rtl/sb_alloc.sv
module sb_alloc #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] occupied,
  output logic                 any_free,
  output logic [IDX_W-1:0]     free_idx
);

  // Lowest-numbered free slot.
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int k = N_ENTRIES - 1; k >= 0; k--) begin
      if (!occupied[k]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/sb_entry_store.sv
module sb_entry_store
  import sb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int LINE_W    = 5,
  parameter int DATA_W    = 16,
  parameter int TID_W     = 2,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_en,
  input  logic [IDX_W-1:0]     ins_idx,
  input  logic [TID_W-1:0]     ins_tid,
  input  logic [DATA_W-1:0]    ins_data,
  input  logic [LINE_W-1:0]    ins_dst,
  input  logic [LINE_W-1:0]    ins_src_a,
  input  logic                 ins_wait_a,
  input  logic [LINE_W-1:0]    ins_src_b,
  input  logic                 ins_wait_b,
  input  logic                 ins_busy,
  input  logic                 wr_evt,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic                 rd_evt,
  input  logic [LINE_W-1:0]    rd_line,
  input  logic [N_ENTRIES-1:0] free_mask,
  input  logic [IDX_W-1:0]     sel_idx,
  output logic [N_ENTRIES-1:0] valid_vec,
  output logic [N_ENTRIES-1:0] ready_vec,
  output logic [TID_W-1:0]     sel_tid,
  output logic [DATA_W-1:0]    sel_data,
  output logic [LINE_W-1:0]    sel_dst
);

  logic      [TID_W-1:0]  tid_q   [N_ENTRIES];
  logic      [DATA_W-1:0] data_q  [N_ENTRIES];
  logic      [LINE_W-1:0] dst_q   [N_ENTRIES];
  logic      [LINE_W-1:0] srca_q  [N_ENTRIES];
  logic      [LINE_W-1:0] srcb_q  [N_ENTRIES];
  sb_flags_t              flags_q [N_ENTRIES];

  // Conditions of an incoming instruction, with same-cycle events applied.
  sb_flags_t ins_flags;
  always_comb begin
    ins_flags.wait_a   = ins_wait_a & ~(wr_evt && ins_src_a == wr_line);
    ins_flags.wait_b   = ins_wait_b & ~(wr_evt && ins_src_b == wr_line);
    ins_flags.busy_dst = ins_busy   & ~(rd_evt && ins_dst   == rd_line);
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
    logic take;
    logic hit_a, hit_b, hit_d;
    assign take  = ins_en && (ins_idx == IDX_W'(i));
    assign hit_a = wr_evt && (srca_q[i] == wr_line);
    assign hit_b = wr_evt && (srcb_q[i] == wr_line);
    assign hit_d = rd_evt && (dst_q[i]  == rd_line);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[i] <= 1'b0;
        flags_q[i]   <= '0;
        tid_q[i]     <= '0;
        data_q[i]    <= '0;
        dst_q[i]     <= '0;
        srca_q[i]    <= '0;
        srcb_q[i]    <= '0;
      end else if (take) begin
        valid_vec[i] <= 1'b1;
        flags_q[i]   <= ins_flags;
        tid_q[i]     <= ins_tid;
        data_q[i]    <= ins_data;
        dst_q[i]     <= ins_dst;
        srca_q[i]    <= ins_src_a;
        srcb_q[i]    <= ins_src_b;
      end else if (free_mask[i]) begin
        valid_vec[i] <= 1'b0;
        flags_q[i]   <= '0;
      end else if (valid_vec[i]) begin
        // broadcast wake-up: every slot compares in parallel
        flags_q[i].wait_a   <= flags_q[i].wait_a   & ~hit_a;
        flags_q[i].wait_b   <= flags_q[i].wait_b   & ~hit_b;
        flags_q[i].busy_dst <= flags_q[i].busy_dst & ~hit_d;
      end
    end

    assign ready_vec[i] = valid_vec[i] & ~flags_q[i].wait_a & ~flags_q[i].wait_b
                          & ~flags_q[i].busy_dst;

    // After a write event no occupied slot still waits on that line.
    assert_wake_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> !(valid_vec[i] &&
                   ((flags_q[i].wait_a && srca_q[i] == $past(wr_line)) ||
                    (flags_q[i].wait_b && srcb_q[i] == $past(wr_line)))));
  end

  assign sel_tid  = tid_q[sel_idx];
  assign sel_data = data_q[sel_idx];
  assign sel_dst  = dst_q[sel_idx];

endmodule

// File: rtl/sb_order_matrix.sv
module sb_order_matrix #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_en,
  input  logic [IDX_W-1:0]     ins_idx,
  input  logic [N_ENTRIES-1:0] valid_vec,
  input  logic [N_ENTRIES-1:0] free_mask,
  input  logic [N_ENTRIES-1:0] cand,
  output logic [N_ENTRIES-1:0] grant
);

  // row_q[i][j] = 1: slot j was inserted before slot i and is still held.
  logic [N_ENTRIES-1:0] row_q [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q[i] <= '0;
      end else if (free_mask[i]) begin
        row_q[i] <= '0;
      end else if (ins_en && ins_idx == IDX_W'(i)) begin
        row_q[i] <= valid_vec & ~free_mask;
      end else begin
        row_q[i] <= row_q[i] & ~free_mask;
      end
    end

    // Oldest candidate: no older slot is also a candidate.
    assign grant[i] = cand[i] & ~|(row_q[i] & cand);

    for (genvar j = 0; j < N_ENTRIES; j++) begin : g_col
      if (i != j) begin : g_pair
        assert_matrix_antisym_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (valid_vec[i] && valid_vec[j]) |-> (row_q[i][j] ^ row_q[j][i]));
        assert_free_column_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
          !valid_vec[j] |-> !row_q[i][j]);
      end
    end

    assert_free_row_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_vec[i] |-> (row_q[i] == '0));
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((|cand) == (|grant)));

endmodule

// File: rtl/sb_stall_buffer.sv
module sb_stall_buffer #(
  parameter int N_ENTRIES = 8,
  parameter int LINE_W    = 5,
  parameter int DATA_W    = 16,
  parameter int TID_W     = 2,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LINE_W-1:0] in_dst,
  input  logic [LINE_W-1:0] in_src_a,
  input  logic              in_wait_a,
  input  logic [LINE_W-1:0] in_src_b,
  input  logic              in_wait_b,
  input  logic              in_dst_busy,
  input  logic              wr_evt_valid,
  input  logic [LINE_W-1:0] wr_evt_line,
  input  logic              rd_evt_valid,
  input  logic [LINE_W-1:0] rd_evt_line,
  input  logic              del_valid,
  input  logic [IDX_W-1:0]  del_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx,
  output logic [TID_W-1:0]  out_tid,
  output logic [DATA_W-1:0] out_data,
  output logic [LINE_W-1:0] out_dst
);

  logic [N_ENTRIES-1:0] valid_vec, ready_vec, cand, grant, del_mask, free_mask;
  logic [IDX_W-1:0]     alloc_idx;
  logic                 ins_en;

  sb_alloc #(.N_ENTRIES(N_ENTRIES)) u_alloc (
    .occupied (valid_vec),
    .any_free (in_ready),
    .free_idx (alloc_idx)
  );

  assign ins_en = in_valid && in_ready;

  always_comb begin
    del_mask = '0;
    if (del_valid) del_mask[del_idx] = 1'b1;
  end

  // A slot being deleted is never offered.
  assign cand      = ready_vec & ~del_mask;
  assign out_valid = |grant;
  assign free_mask = del_mask | ((out_valid && out_ready) ? grant : '0);

  always_comb begin
    out_idx = '0;
    for (int k = 0; k < N_ENTRIES; k++) begin
      if (grant[k]) out_idx = IDX_W'(k);
    end
  end

  sb_entry_store #(
    .N_ENTRIES(N_ENTRIES), .LINE_W(LINE_W), .DATA_W(DATA_W), .TID_W(TID_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_en     (ins_en),
    .ins_idx    (alloc_idx),
    .ins_tid    (in_tid),
    .ins_data   (in_data),
    .ins_dst    (in_dst),
    .ins_src_a  (in_src_a),
    .ins_wait_a (in_wait_a),
    .ins_src_b  (in_src_b),
    .ins_wait_b (in_wait_b),
    .ins_busy   (in_dst_busy),
    .wr_evt     (wr_evt_valid),
    .wr_line    (wr_evt_line),
    .rd_evt     (rd_evt_valid),
    .rd_line    (rd_evt_line),
    .free_mask  (free_mask),
    .sel_idx    (out_idx),
    .valid_vec  (valid_vec),
    .ready_vec  (ready_vec),
    .sel_tid    (out_tid),
    .sel_data   (out_data),
    .sel_dst    (out_dst)
  );

  sb_order_matrix #(.N_ENTRIES(N_ENTRIES)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_en    (ins_en),
    .ins_idx   (alloc_idx),
    .valid_vec (valid_vec),
    .free_mask (free_mask),
    .cand      (cand),
    .grant     (grant)
  );

  assert_full_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> ($countones(valid_vec) == N_ENTRIES));

  assert_insert_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> valid_vec[$past(alloc_idx)]);

  assert_offer_persists_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !del_valid) |=> out_valid);

endmodule

// File: tb/tb_sb_stall_buffer.sv
module tb_sb_stall_buffer;
  localparam int N  = 8;
  localparam int LW = 5;
  localparam int DW = 16;
  localparam int TW = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid = 0, in_wait_a = 0, in_wait_b = 0, in_dst_busy = 0;
  logic          in_ready;
  logic [TW-1:0] in_tid = '0;
  logic [DW-1:0] in_data = '0;
  logic [LW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic          wr_evt_valid = 0, rd_evt_valid = 0, del_valid = 0, out_ready = 0;
  logic [LW-1:0] wr_evt_line = '0, rd_evt_line = '0;
  logic [IW-1:0] del_idx = '0;
  logic          out_valid;
  logic [IW-1:0] out_idx;
  logic [TW-1:0] out_tid;
  logic [DW-1:0] out_data;
  logic [LW-1:0] out_dst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sb_stall_buffer #(.N_ENTRIES(N), .LINE_W(LW), .DATA_W(DW), .TID_W(TW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_tid(in_tid), .in_data(in_data),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_wait_a(in_wait_a),
    .in_src_b(in_src_b), .in_wait_b(in_wait_b), .in_dst_busy(in_dst_busy),
    .wr_evt_valid(wr_evt_valid), .wr_evt_line(wr_evt_line),
    .rd_evt_valid(rd_evt_valid), .rd_evt_line(rd_evt_line),
    .del_valid(del_valid), .del_idx(del_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_tid(out_tid), .out_data(out_data), .out_dst(out_dst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp_v);
    end
  endtask

  // Advance to just after the next rising edge; one-shot strobes drop.
  task automatic cyc();
    @(posedge clk); #1;
    in_valid = 0; wr_evt_valid = 0; rd_evt_valid = 0; del_valid = 0;
  endtask

  task automatic put(input logic [TW-1:0] tid, input logic [DW-1:0] data,
                     input logic [LW-1:0] dst, input logic [LW-1:0] sa, input logic wa,
                     input logic [LW-1:0] sb, input logic wb, input logic busy);
    in_valid = 1; in_tid = tid; in_data = data; in_dst = dst;
    in_src_a = sa; in_wait_a = wa; in_src_b = sb; in_wait_b = wb; in_dst_busy = busy;
    cyc();
  endtask

  task automatic wr_event(input logic [LW-1:0] line);
    wr_evt_valid = 1; wr_evt_line = line;
    cyc();
  endtask

  task automatic pop_expect(input string req, input logic [DW-1:0] data);
    out_ready = 1; #1;
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, {16'd0, out_data}, {16'd0, data});
    cyc();
    out_ready = 0;
  endtask

  task automatic expect_idle(input string req);
    #1; chk(req, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_basic();
    put(2'd1, 16'h0A11, 5'd7, 5'd1, 1'b0, 5'd2, 1'b0, 1'b0);
    #1;
    chk("R2 valid", {31'd0, out_valid}, 32'd1);
    chk("R2 tid", {30'd0, out_tid}, 32'd1);
    chk("R2 dst", {27'd0, out_dst}, 32'd7);
    pop_expect("R2 data", 16'h0A11);
    expect_idle("R2 empty after pop");
  endtask

  task automatic t_broadcast();
    put(2'd1, 16'h00A1, 5'd0, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0);
    put(2'd2, 16'h00B2, 5'd0, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0);
    put(2'd3, 16'h00C3, 5'd0, 5'd6, 1'b1, 5'd0, 1'b0, 1'b0);
    put(2'd0, 16'h00D4, 5'd0, 5'd0, 1'b0, 5'd5, 1'b1, 1'b0);
    expect_idle("R4 all waiting");
    wr_event(5'd5);
    #1; chk("R10 tid of oldest", {30'd0, out_tid}, 32'd1);
    pop_expect("R4 first waiter", 16'h00A1);
    #1; chk("R10 tid of second", {30'd0, out_tid}, 32'd2);
    pop_expect("R10 second thread", 16'h00B2);
    pop_expect("R4 source B waiter", 16'h00D4);
    expect_idle("R4 other line untouched");
    wr_event(5'd6);
    pop_expect("R4 line 6 waiter", 16'h00C3);
  endtask

  task automatic t_full();
    for (int k = 0; k < N; k++)
      put(2'(k), DW'(16'h0040 + k), 5'd0, 5'd20, 1'b1, 5'd0, 1'b0, 1'b0);
    #1; chk("R3 in_ready when full", {31'd0, in_ready}, 32'd0);
    put(2'd0, 16'h00EE, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    expect_idle("R3 ignored insert not offered");
    wr_event(5'd20);
    for (int k = 0; k < N; k++) pop_expect("R5 drain order", DW'(16'h0040 + k));
    expect_idle("R3 nothing extra stored");
    #1; chk("R3 in_ready after drain", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_delete();
    logic [IW-1:0] first;
    put(2'd0, 16'h0051, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    put(2'd1, 16'h0052, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    #1; chk("R6 oldest offered", {16'd0, out_data}, 32'h0051);
    first = out_idx;
    del_valid = 1; del_idx = first; #1;
    chk("R6 deleted slot masked", {16'd0, out_data}, 32'h0052);
    cyc();
    pop_expect("R6 survivor", 16'h0052);
    expect_idle("R6 deleted never dispatched");
  endtask

  task automatic t_bypass();
    in_valid = 1; in_tid = 2'd2; in_data = 16'h0061; in_dst = 5'd0;
    in_src_a = 5'd9; in_wait_a = 1; in_src_b = 5'd0; in_wait_b = 0; in_dst_busy = 0;
    wr_evt_valid = 1; wr_evt_line = 5'd9;
    cyc();
    pop_expect("R7 same-cycle wake", 16'h0061);
  endtask

  task automatic t_dst_busy();
    put(2'd3, 16'h0071, 5'd3, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1);
    wr_event(5'd3);
    expect_idle("R8 write event does not free dst");
    rd_evt_valid = 1; rd_evt_line = 5'd4; cyc();
    expect_idle("R8 read of other line");
    rd_evt_valid = 1; rd_evt_line = 5'd3; cyc();
    pop_expect("R8 released by read", 16'h0071);
  endtask

  task automatic t_backpressure();
    put(2'd0, 16'h0081, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9 held valid", {31'd0, out_valid}, 32'd1);
      chk("R9 held data", {16'd0, out_data}, 32'h0081);
      cyc();
    end
    pop_expect("R9 finally taken", 16'h0081);
  endtask

  task automatic t_reuse();
    put(2'd0, 16'h0091, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    put(2'd1, 16'h0092, 5'd0, 5'd12, 1'b1, 5'd0, 1'b0, 1'b0);
    pop_expect("R5 first", 16'h0091);
    put(2'd2, 16'h0093, 5'd0, 5'd12, 1'b1, 5'd0, 1'b0, 1'b0);
    wr_event(5'd12);
    pop_expect("R5 older despite higher slot", 16'h0092);
    pop_expect("R5 reused slot second", 16'h0093);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    t_reset();
    t_basic();
    t_broadcast();
    t_full();
    t_delete();
    t_bypass();
    t_dst_busy();
    t_backpressure();
    t_reuse();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule